// File: doc/BRIEF.md
# CEC Bus Controller Register Front End and Message Sequencer

This block sits between a 32-bit register port and a byte-level consumer-electronics-control line engine. Software enables the controller, programs the logical addresses the node answers to, and sends a frame one byte at a time. Two control bits mark the frame: one starts it and one marks the final byte. The block hands each byte to the line engine with header and last-byte markers. After each non-final byte is taken, it raises a byte request so that software can load the next byte. It latches every outcome the engine reports in a write-one-to-clear status register and drives a single interrupt from the enabled status bits.

On the receive side, the block looks at the destination nibble of each incoming header. It keeps the frame only when the destination is one of the node's own addresses, is the broadcast address, or listen-all is set. Accepted bytes are presented in a receive data register. A byte that arrives before software has cleared the previous byte-ready flag is dropped and flagged as an overrun. Timing of the bit-level waveform on the wire belongs to the line engine, not to this block.

Top module: `cec_regfront`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `ln_tx_valid` is 0.
- R2: Registers sit at word offsets 0x00 control, 0x04 configuration, 0x08 transmit data, 0x0C receive data, 0x10 status, 0x14 interrupt enable. Control holds enable in bit 0, start in bit 1 and end in bit 2. Configuration holds listen-all in bit 31 and the own-address mask in bits 30:16, where bit 16+n stands for logical address n. Bits with no function read 0. The enable register keeps only the status bit positions listed in R3.
- R3: Status bits are: 0 receive byte ready, 1 receive end, 2 receive overrun, 6 receive acknowledge error, 7 arbitration lost, 8 transmit byte request, 9 transmit end, 10 transmit underrun, 11 transmit error, 12 transmit acknowledge error. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: With start set, a pending transmit byte is presented with `ln_tx_first`=1 as the header. Each `ln_tx_next` while a byte is presented consumes that byte. When the consumed byte is not the last one, bit 8 is set and the frame continues. The presented byte carries `ln_tx_last`=1 when end is set, and consuming it sets no bit 8.
- R5: When end is written before start, the frame is a single byte that is both header and last.
- R6: Start reads 1 from the moment it is set until the frame ends. `ln_tx_done` after the last byte sets bit 9 and clears both start and end.
- R7: During a frame, `ln_tx_err`, `ln_tx_arblost` or `ln_tx_ackerr` sets bit 11, 7 or 12 respectively. It also ends the frame, clears start and end, and discards any pending byte.
- R8: If `ln_tx_next` arrives after the header while no byte is pending, bit 10 is set, `ln_tx_abort` pulses and the frame ends with start and end cleared.
- R9: An accepted received byte sets bit 0 and appears in receive data bits 7:0. If it is marked last, it also sets bit 1. `ln_rx_ackerr` sets bit 6.
- R10: A frame is accepted only if its header's low nibble (destination) has its own-address mask bit set, is 15 (broadcast), or listen-all is set. Bytes of a rejected frame change neither status nor receive data.
- R11: An accepted byte that arrives while bit 0 is still set sets bit 2 and is dropped. Receive data keeps the earlier byte, and bit 1 is not set.
- R12: While enable is 0, start and end read 0 and cannot be set, nothing is presented to the engine, pending data is discarded and received bytes are ignored.
- R13: `irq` is 1 exactly when some status bit is set whose enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Masked interrupt |
| ln_tx_valid | output | 1 | A transmit byte is presented to the engine |
| ln_tx_byte | output | BYTE_W | Presented byte |
| ln_tx_first | output | 1 | Presented byte is the header |
| ln_tx_last | output | 1 | Presented byte ends the frame |
| ln_tx_abort | output | 1 | Frame aborted by the block (underrun or disable) |
| ln_tx_next | input | 1 | Engine takes the presented byte or demands one |
| ln_tx_done | input | 1 | Frame completed on the line |
| ln_tx_err | input | 1 | Line error during transmit |
| ln_tx_arblost | input | 1 | Arbitration lost |
| ln_tx_ackerr | input | 1 | Transmitted byte not acknowledged |
| ln_rx_valid | input | 1 | Received byte strobe |
| ln_rx_byte | input | BYTE_W | Received byte |
| ln_rx_first | input | 1 | Received byte is a header |
| ln_rx_last | input | 1 | Received byte ends the frame |
| ln_rx_ackerr | input | 1 | Receive acknowledge error |

## Verification
The hardest cases to reach are those where the engine's timing races software. One is a byte demand that lands after a byte request that software has not answered yet. Another is a received byte that arrives while byte ready is still set. The bench reaches the underrun by consuming the header, leaving the request unanswered and pulsing the demand again. It reaches the overrun by sending a broadcast header followed by a second byte before clearing the ready flag. In both cases it then checks the status flags, the receive data and the start bit at the register port.

// File: rtl/cec_rf_pkg.sv
package cec_rf_pkg;
    localparam int REG_W = 32;

    // word index of each register (byte offset / 4)
    localparam int RI_CTRL = 0;
    localparam int RI_CFG  = 1;
    localparam int RI_TXD  = 2;
    localparam int RI_RXD  = 3;
    localparam int RI_ISR  = 4;
    localparam int RI_IER  = 5;

    // control bits
    localparam int CB_EN  = 0;
    localparam int CB_SOM = 1;
    localparam int CB_EOM = 2;

    // configuration fields
    localparam int CF_LISTEN  = 31;
    localparam int CF_OWN_LSB = 16;

    // status bit positions
    localparam int SB_RXBR   = 0;
    localparam int SB_RXEND  = 1;
    localparam int SB_RXOVR  = 2;
    localparam int SB_RXACKE = 6;
    localparam int SB_ARBLST = 7;
    localparam int SB_TXBR   = 8;
    localparam int SB_TXEND  = 9;
    localparam int SB_TXUDR  = 10;
    localparam int SB_TXERR  = 11;
    localparam int SB_TXACKE = 12;
    localparam logic [REG_W-1:0] SB_MASK = 32'h0000_1FC7;

    typedef enum logic [1:0] {
        TXS_IDLE,
        TXS_HEAD,
        TXS_BODY,
        TXS_TAIL
    } tx_state_e;
endpackage

// File: rtl/cec_rf_txseq.sv
module cec_rf_txseq
    import cec_rf_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              som_set,
    input  logic              eom_set,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              ln_next,
    input  logic              ln_done,
    input  logic              ln_err,
    input  logic              ln_arblost,
    input  logic              ln_ackerr,
    output logic              som,
    output logic              eom,
    output logic [BYTE_W-1:0] buf_byte,
    output logic              tx_valid,
    output logic              tx_first,
    output logic              tx_abort,
    output logic              ev_txbr,
    output logic              ev_txend,
    output logic              ev_udr,
    output logic              ev_err,
    output logic              ev_arb,
    output logic              ev_acke
);
    typedef struct packed {
        tx_state_e         state;
        logic              som;
        logic              eom;
        logic              pend;
        logic [BYTE_W-1:0] buf_b;
    } seq_t;

    seq_t q, d;
    logic busy, line_fault;

    assign busy       = (q.state != TXS_IDLE);
    assign tx_valid   = q.pend && ((q.state == TXS_HEAD) || (q.state == TXS_BODY));
    assign tx_first   = (q.state == TXS_HEAD);
    assign line_fault = busy && (ln_err || ln_arblost || ln_ackerr);
    assign som        = q.som;
    assign eom        = q.eom;
    assign buf_byte   = q.buf_b;

    always_comb begin
        d        = q;
        tx_abort = 1'b0;
        ev_txbr  = 1'b0;
        ev_txend = 1'b0;
        ev_udr   = 1'b0;
        ev_err   = 1'b0;
        ev_arb   = 1'b0;
        ev_acke  = 1'b0;

        if (data_wr) begin
            d.buf_b = data_in;
            d.pend  = en;
        end
        if (eom_set && en) d.eom = 1'b1;
        if (som_set && en && !busy) begin
            d.som   = 1'b1;
            d.state = TXS_HEAD;
        end

        if (!en) begin
            tx_abort = busy;
            d.state  = TXS_IDLE;
            d.som    = 1'b0;
            d.eom    = 1'b0;
            d.pend   = 1'b0;
        end else if (line_fault) begin
            ev_err  = ln_err;
            ev_arb  = ln_arblost;
            ev_acke = ln_ackerr;
            d.state = TXS_IDLE;
            d.som   = 1'b0;
            d.eom   = 1'b0;
            d.pend  = 1'b0;
        end else if (ln_next && busy && tx_valid) begin
            d.pend = data_wr;
            if (q.eom) begin
                d.state = TXS_TAIL;
            end else begin
                d.state = TXS_BODY;
                ev_txbr = 1'b1;
            end
        end else if (ln_next && (q.state == TXS_BODY)) begin
            ev_udr   = 1'b1;
            tx_abort = 1'b1;
            d.state  = TXS_IDLE;
            d.som    = 1'b0;
            d.eom    = 1'b0;
            d.pend   = 1'b0;
        end else if (ln_done && (q.state == TXS_TAIL)) begin
            ev_txend = 1'b1;
            d.state  = TXS_IDLE;
            d.som    = 1'b0;
            d.eom    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: TXS_IDLE, som: 1'b0, eom: 1'b0, pend: 1'b0, buf_b: '0};
        end else begin
            q <= d;
        end
    end

    // R7: a line fault during a frame ends it
    a_r7_fault_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (en && line_fault) |=> (q.state == TXS_IDLE && !q.som));

    // R6: start only falls on a completion, fault, demand or disable
    a_r6_som_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.som) |-> $past(ln_done || ln_err || ln_arblost || ln_ackerr || ln_next || !en));

    // R6: end never outlives start
    a_r6_eom_with_som: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.som) |-> !q.eom);

    // R8: a demand with nothing pending mid-frame drops to idle
    a_r8_udr_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !line_fault && ln_next && q.state == TXS_BODY && !q.pend) |=> (q.state == TXS_IDLE));
endmodule

// File: rtl/cec_rf_rxpath.sv
module cec_rf_rxpath #(
    parameter int BYTE_W  = 8,
    parameter int N_LADDR = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               listen,
    input  logic [N_LADDR-1:0] own_mask,
    input  logic               ready_busy,
    input  logic               ln_valid,
    input  logic [BYTE_W-1:0]  ln_byte,
    input  logic               ln_first,
    input  logic               ln_last,
    output logic [BYTE_W-1:0]  rx_data,
    output logic               ev_br,
    output logic               ev_end,
    output logic               ev_ovr
);
    localparam int DEST_W = $clog2(N_LADDR + 1);

    typedef struct packed {
        logic              match;
        logic [BYTE_W-1:0] data;
    } rx_t;

    rx_t q, d;
    logic [N_LADDR:0]   addr_ok;
    logic [DEST_W-1:0]  dest;
    logic               hit, accept;

    // top entry stands for the broadcast address
    assign addr_ok = {1'b1, own_mask};
    assign dest    = ln_byte[DEST_W-1:0];
    assign hit     = listen || addr_ok[dest];
    assign accept  = en && ln_valid && (ln_first ? hit : q.match);
    assign rx_data = q.data;

    always_comb begin
        d      = q;
        ev_br  = 1'b0;
        ev_end = 1'b0;
        ev_ovr = 1'b0;
        if (!en) begin
            d.match = 1'b0;
        end else if (ln_valid && ln_first) begin
            d.match = hit;
        end
        if (accept) begin
            if (ready_busy) begin
                ev_ovr = 1'b1;
            end else begin
                d.data = ln_byte;
                ev_br  = 1'b1;
                ev_end = ln_last;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{match: 1'b0, data: '0};
        end else begin
            q <= d;
        end
    end

    // R11: a dropped byte leaves the data register alone
    a_r11_ovr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovr |=> $stable(q.data));

    // R10: a rejected header never produces a byte-ready event
    a_r10_reject_header: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_valid && ln_first && !hit) |-> !ev_br);
endmodule

// File: rtl/cec_regfront.sv
module cec_regfront
    import cec_rf_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int BYTE_W  = 8,
    parameter int N_LADDR = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              ln_tx_valid,
    output logic [BYTE_W-1:0] ln_tx_byte,
    output logic              ln_tx_first,
    output logic              ln_tx_last,
    output logic              ln_tx_abort,
    input  logic              ln_tx_next,
    input  logic              ln_tx_done,
    input  logic              ln_tx_err,
    input  logic              ln_tx_arblost,
    input  logic              ln_tx_ackerr,
    input  logic              ln_rx_valid,
    input  logic [BYTE_W-1:0] ln_rx_byte,
    input  logic              ln_rx_first,
    input  logic              ln_rx_last,
    input  logic              ln_rx_ackerr
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic               en;
        logic               listen;
        logic [N_LADDR-1:0] own;
        logic [REG_W-1:0]   isr;
        logic [REG_W-1:0]   ier;
    } regs_t;

    regs_t q, d;
    logic [IDX_W-1:0]  idx;
    logic              wr_ctrl, wr_cfg, wr_txd, wr_isr, wr_ier, en_eff;
    logic              som, eom;
    logic [BYTE_W-1:0] tx_buf, rx_data;
    logic              ev_txbr, ev_txend, ev_udr, ev_err, ev_arb, ev_acke;
    logic              ev_br, ev_end, ev_ovr;
    logic [REG_W-1:0]  set_v;

    assign idx     = reg_addr[ADDR_W-1:2];
    assign wr_ctrl = reg_wr && (idx == IDX_W'(RI_CTRL));
    assign wr_cfg  = reg_wr && (idx == IDX_W'(RI_CFG));
    assign wr_txd  = reg_wr && (idx == IDX_W'(RI_TXD));
    assign wr_isr  = reg_wr && (idx == IDX_W'(RI_ISR));
    assign wr_ier  = reg_wr && (idx == IDX_W'(RI_IER));
    assign en_eff  = wr_ctrl ? reg_wdata[CB_EN] : q.en;

    cec_rf_txseq #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_eff),
        .som_set   (wr_ctrl && reg_wdata[CB_SOM]),
        .eom_set   (wr_ctrl && reg_wdata[CB_EOM]),
        .data_wr   (wr_txd),
        .data_in   (reg_wdata[BYTE_W-1:0]),
        .ln_next   (ln_tx_next),
        .ln_done   (ln_tx_done),
        .ln_err    (ln_tx_err),
        .ln_arblost(ln_tx_arblost),
        .ln_ackerr (ln_tx_ackerr),
        .som       (som),
        .eom       (eom),
        .buf_byte  (tx_buf),
        .tx_valid  (ln_tx_valid),
        .tx_first  (ln_tx_first),
        .tx_abort  (ln_tx_abort),
        .ev_txbr   (ev_txbr),
        .ev_txend  (ev_txend),
        .ev_udr    (ev_udr),
        .ev_err    (ev_err),
        .ev_arb    (ev_arb),
        .ev_acke   (ev_acke)
    );

    cec_rf_rxpath #(.BYTE_W(BYTE_W), .N_LADDR(N_LADDR)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_eff),
        .listen    (q.listen),
        .own_mask  (q.own),
        .ready_busy(q.isr[SB_RXBR]),
        .ln_valid  (ln_rx_valid),
        .ln_byte   (ln_rx_byte),
        .ln_first  (ln_rx_first),
        .ln_last   (ln_rx_last),
        .rx_data   (rx_data),
        .ev_br     (ev_br),
        .ev_end    (ev_end),
        .ev_ovr    (ev_ovr)
    );

    assign ln_tx_byte = tx_buf;
    assign ln_tx_last = eom;
    assign irq        = |(q.isr & q.ier);

    always_comb begin
        set_v            = '0;
        set_v[SB_RXBR]   = ev_br;
        set_v[SB_RXEND]  = ev_end;
        set_v[SB_RXOVR]  = ev_ovr;
        set_v[SB_RXACKE] = en_eff && ln_rx_ackerr;
        set_v[SB_ARBLST] = ev_arb;
        set_v[SB_TXBR]   = ev_txbr;
        set_v[SB_TXEND]  = ev_txend;
        set_v[SB_TXUDR]  = ev_udr;
        set_v[SB_TXERR]  = ev_err;
        set_v[SB_TXACKE] = ev_acke;
    end

    always_comb begin
        d = q;
        if (wr_ctrl) d.en = reg_wdata[CB_EN];
        if (wr_cfg) begin
            d.listen = reg_wdata[CF_LISTEN];
            d.own    = reg_wdata[CF_OWN_LSB +: N_LADDR];
        end
        if (wr_ier) d.ier = reg_wdata & SB_MASK;
        d.isr = ((q.isr & ~(wr_isr ? reg_wdata : '0)) | set_v) & SB_MASK;
    end

    always_comb begin
        reg_rdata = '0;
        case (idx)
            IDX_W'(RI_CTRL): begin
                reg_rdata[CB_EN]  = q.en;
                reg_rdata[CB_SOM] = som;
                reg_rdata[CB_EOM] = eom;
            end
            IDX_W'(RI_CFG): begin
                reg_rdata[CF_LISTEN]                 = q.listen;
                reg_rdata[CF_OWN_LSB +: N_LADDR]     = q.own;
            end
            IDX_W'(RI_TXD): reg_rdata[BYTE_W-1:0] = tx_buf;
            IDX_W'(RI_RXD): reg_rdata[BYTE_W-1:0] = rx_data;
            IDX_W'(RI_ISR): reg_rdata = q.isr;
            IDX_W'(RI_IER): reg_rdata = q.ier;
            default:        reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{en: 1'b0, listen: 1'b0, own: '0, isr: '0, ier: '0};
        end else begin
            q <= d;
        end
    end

    // R12: with enable low and not being written high, start stays low
    a_r12_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en && !(wr_ctrl && reg_wdata[CB_EN])) |=> !som);

    // R8: an underrun event is recorded in the status register
    a_r8_udr_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        ev_udr |=> q.isr[SB_TXUDR]);

    // R3: a status bit without a new event clears when written with 1
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_isr && reg_wdata[SB_TXEND] && !ev_txend) |=> !q.isr[SB_TXEND]);

    // R4: the byte request bit appears after a consumed non-last byte
    a_r4_txbr_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txbr |=> q.isr[SB_TXBR]);
endmodule

// File: tb/tb_cec_regfront.sv
module tb_cec_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        tx_valid, tx_first, tx_last, tx_abort;
    logic [7:0]  tx_byte;
    logic        tx_next = 0, tx_done = 0, tx_err = 0, tx_arb = 0, tx_acke = 0;
    logic        rx_valid = 0, rx_first = 0, rx_last = 0, rx_acke = 0;
    logic [7:0]  rx_byte = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_TXD = 5'h08,
                           A_RXD = 5'h0C, A_ISR = 5'h10, A_IER = 5'h14;

    always #5 clk = ~clk;

    cec_regfront dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .ln_tx_valid(tx_valid), .ln_tx_byte(tx_byte), .ln_tx_first(tx_first),
        .ln_tx_last(tx_last), .ln_tx_abort(tx_abort), .ln_tx_next(tx_next),
        .ln_tx_done(tx_done), .ln_tx_err(tx_err), .ln_tx_arblost(tx_arb),
        .ln_tx_ackerr(tx_acke), .ln_rx_valid(rx_valid), .ln_rx_byte(rx_byte),
        .ln_rx_first(rx_first), .ln_rx_last(rx_last), .ln_rx_ackerr(rx_acke)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [4:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // one-cycle pulse on an engine input, selected by code
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tx_next = 1; 1: tx_done = 1; 2: tx_err = 1;
            3: tx_arb = 1;  4: tx_acke = 1; default: rx_acke = 1;
        endcase
        @(negedge clk);
        tx_next = 0; tx_done = 0; tx_err = 0; tx_arb = 0; tx_acke = 0; rx_acke = 0;
    endtask

    task automatic rx(input logic [7:0] b, input logic first, input logic last);
        @(negedge clk);
        rx_valid = 1; rx_byte = b; rx_first = first; rx_last = last;
        @(negedge clk);
        rx_valid = 0; rx_first = 0; rx_last = 0;
    endtask

    task automatic t_reset();
        rdchk("R1 ctrl", A_CTRL, 0); rdchk("R1 cfg", A_CFG, 0);
        rdchk("R1 txd", A_TXD, 0);   rdchk("R1 rxd", A_RXD, 0);
        rdchk("R1 isr", A_ISR, 0);   rdchk("R1 ier", A_IER, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    endtask

    task automatic t_regs();
        wr(A_CFG, 32'h8002_FFFF);
        rdchk("R2 cfg fields", A_CFG, 32'h8002_0000);
        wr(A_IER, 32'hFFFF_FFFF);
        rdchk("R2 ier bits", A_IER, 32'h0000_1FC7);
        wr(A_IER, 0);
        wr(A_CTRL, 32'hFFFF_FFF9);
        rdchk("R2 ctrl enable only", A_CTRL, 32'h1);
    endtask

    task automatic t_tx_multi();
        wr(A_CTRL, 3);
        rdchk("R6 som reads 1", A_CTRL, 3);
        chk("R4 nothing pending", {31'b0, tx_valid}, 0);
        wr(A_TXD, 32'h40);
        chk("R4 header presented", {22'b0, tx_valid, tx_first, tx_byte}, {22'b0, 2'b11, 8'h40});
        chk("R4 header not last", {31'b0, tx_last}, 0);
        pulse(0);
        rdchk("R4 byte request", A_ISR, 32'h100);
        chk("R4 consumed", {31'b0, tx_valid}, 0);
        wr(A_ISR, 32'h100);
        rdchk("R3 w1c", A_ISR, 0);
        wr(A_TXD, 32'h82);
        wr(A_CTRL, 7);
        chk("R4 last presented", {21'b0, tx_valid, tx_first, tx_last, tx_byte}, {21'b0, 3'b101, 8'h82});
        pulse(0);
        rdchk("R4 no request after last", A_ISR, 0);
        rdchk("R6 som held in tail", A_CTRL, 7);
        pulse(1);
        rdchk("R6 tx end", A_ISR, 32'h200);
        rdchk("R6 som eom cleared", A_CTRL, 1);
        wr(A_ISR, 32'hFFFF_FFFF);
    endtask

    task automatic t_tx_one();
        wr(A_CTRL, 5);
        wr(A_CTRL, 7);
        wr(A_TXD, 32'h4F);
        chk("R5 single byte", {21'b0, tx_valid, tx_first, tx_last, tx_byte}, {21'b0, 3'b111, 8'h4F});
        pulse(0);
        rdchk("R5 no request", A_ISR, 0);
        pulse(1);
        rdchk("R5 end", A_ISR, 32'h200);
        rdchk("R5 ctrl idle", A_CTRL, 1);
        wr(A_ISR, 32'hFFFF_FFFF);
    endtask

    task automatic t_abort();
        wr(A_CTRL, 3); wr(A_TXD, 32'h41);
        pulse(3);
        rdchk("R7 arb lost", A_ISR, 32'h80);
        rdchk("R7 som cleared", A_CTRL, 1);
        chk("R7 pending dropped", {31'b0, tx_valid}, 0);
        wr(A_ISR, 32'hFFFF_FFFF);
        wr(A_CTRL, 3); wr(A_TXD, 32'h41); pulse(0);
        wr(A_CTRL, 7); wr(A_TXD, 32'h11); pulse(0);
        pulse(4);
        rdchk("R7 ack error", A_ISR, 32'h1100);
        rdchk("R7 ack ctrl", A_CTRL, 1);
        wr(A_ISR, 32'hFFFF_FFFF);
        wr(A_CTRL, 3); wr(A_TXD, 32'h41);
        pulse(2);
        rdchk("R7 line error", A_ISR, 32'h800);
        rdchk("R7 err ctrl", A_CTRL, 1);
        wr(A_ISR, 32'hFFFF_FFFF);
    endtask

    task automatic t_underrun();
        wr(A_CTRL, 3); wr(A_TXD, 32'h42);
        pulse(0);
        @(negedge clk);
        tx_next = 1;
        #1;
        chk("R8 abort pulse", {31'b0, tx_abort}, 1);
        @(negedge clk);
        tx_next = 0;
        rdchk("R8 underrun flag", A_ISR, 32'h500);
        rdchk("R8 ctrl cleared", A_CTRL, 1);
        wr(A_ISR, 32'hFFFF_FFFF);
    endtask

    task automatic t_rx_filter();
        wr(A_CFG, 32'h0010_0000);
        rx(8'h04, 1, 0);
        rdchk("R9 byte ready", A_ISR, 32'h1);
        rdchk("R9 header data", A_RXD, 32'h04);
        wr(A_ISR, 1);
        rx(8'h99, 0, 1);
        rdchk("R9 end", A_ISR, 32'h3);
        rdchk("R9 data", A_RXD, 32'h99);
        wr(A_ISR, 32'hFFFF_FFFF);
        rx(8'h03, 1, 0);
        rdchk("R10 other dest ignored", A_ISR, 0);
        rx(8'h55, 0, 1);
        rdchk("R10 rest ignored", A_ISR, 0);
        rdchk("R10 data kept", A_RXD, 32'h99);
        rx(8'h0F, 1, 1);
        rdchk("R10 broadcast", A_ISR, 32'h3);
        wr(A_ISR, 32'hFFFF_FFFF);
        wr(A_CFG, 32'h8000_0000);
        rx(8'h03, 1, 0);
        rdchk("R10 listen all", A_ISR, 32'h1);
        rdchk("R10 listen data", A_RXD, 32'h03);
        wr(A_ISR, 32'hFFFF_FFFF);
        pulse(5);
        rdchk("R9 rx ack error", A_ISR, 32'h40);
        wr(A_ISR, 32'hFFFF_FFFF);
    endtask

    task automatic t_overrun();
        wr(A_CFG, 0);
        rx(8'h0F, 1, 0);
        rx(8'h77, 0, 1);
        rdchk("R11 overrun flag", A_ISR, 32'h5);
        rdchk("R11 byte dropped", A_RXD, 32'h0F);
    endtask

    task automatic t_irq();
        wr(A_ISR, 32'hFFFF_FFFF);
        pulse(5);
        chk("R13 masked", {31'b0, irq}, 0);
        wr(A_IER, 32'h40);
        chk("R13 enabled", {31'b0, irq}, 1);
        wr(A_ISR, 32'h1);
        rdchk("R3 other bit kept", A_ISR, 32'h40);
        wr(A_ISR, 32'h40);
        chk("R13 cleared", {31'b0, irq}, 0);
        wr(A_IER, 0);
    endtask

    task automatic t_disable();
        wr(A_CTRL, 3); wr(A_TXD, 32'h44);
        chk("R12 presented before", {31'b0, tx_valid}, 1);
        wr(A_CTRL, 0);
        rdchk("R12 ctrl off", A_CTRL, 0);
        chk("R12 nothing presented", {31'b0, tx_valid}, 0);
        wr(A_CTRL, 6);
        rdchk("R12 som ignored", A_CTRL, 0);
        rx(8'h0F, 1, 1);
        rdchk("R12 rx ignored", A_ISR, 0);
        wr(A_CTRL, 1);
        chk("R12 pending discarded", {31'b0, tx_valid}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_tx_multi();
        t_tx_one();
        t_abort();
        t_underrun();
        t_rx_filter();
        t_overrun();
        t_irq();
        t_disable();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule